// File: doc/BRIEF.md
# Processor Subsystem Reset Distributor

This block produces the three reset lines of a processor subsystem: one for the debug logic, one for the processor core and one for the power-management unit. Each line is active low. It asserts as soon as a request arrives, with no clock edge needed. It is released only after a hold time, followed by a synchronizer clocked by the local clock, so that release always lines up with a clock edge.

Three sources can request a reset, and each one reaches a different set of lines. The power-on sequencer (`por_req`) is a level input that pulls all three lines low. The debugger (`dbg_req`) is a level input that pulls only the core line low, so the debug connection survives. The interrupt controller's software system-reset request (`sw_req`) also reaches only the core line. That request is edge-captured into a single internal pulse, so a request line left high by a core that is itself in reset cannot hold the core in reset forever.

After power-up, the sequencer holds `por_req` high. When it lowers `por_req`, all three lines are released on the same clock edge.

Top module: `cpu_reset_dist`

## Requirements
- R1: While `por_req` is high, `dbg_rst_n`, `core_rst_n` and `pmu_rst_n` are all 0. They go low as soon as `por_req` rises, before any clock edge.
- R2: After `por_req` falls, all three outputs rise together on the (HOLD_CYCLES+SYNC_STAGES)-th rising clock edge. With the defaults 4 and 2, that is the 6th edge.
- R3: `dbg_req` high drives `core_rst_n` to 0 at once, before any clock edge, and holds it there while `dbg_req` stays high.
- R4: After `dbg_req` falls, `core_rst_n` rises on the (HOLD_CYCLES+SYNC_STAGES)-th rising edge. The core is therefore held for at least HOLD_CYCLES clocks after any request goes away.
- R5: If `sw_req` is 0 at one rising edge and 1 at the next, `core_rst_n` falls on that second edge. It rises again HOLD_CYCLES+SYNC_STAGES edges after the edge that follows.
- R6: A `sw_req` held high causes exactly one core reset. Another reset needs `sw_req` to be seen low on at least one edge and then high again.
- R7: A `sw_req` that is already high while `por_req` is high causes no core reset after `por_req` falls.
- R8: `dbg_req` and `sw_req` never pull `dbg_rst_n` or `pmu_rst_n` low. Those two lines respond to `por_req` alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock of the processor subsystem |
| por_req | input | 1 | Power-on sequencer request, active high; resets all three domains |
| dbg_req | input | 1 | Debugger reset request, active-high level; resets the core only |
| sw_req | input | 1 | Software system-reset request from the interrupt controller; a rising edge resets the core only |
| dbg_rst_n | output | 1 | Debug logic reset, active low |
| core_rst_n | output | 1 | Processor core reset, active low |
| pmu_rst_n | output | 1 | Power-management unit reset, active low |

## Verification
The bench counts the exact release edge of every source at each clock. A hold counter or synchronizer that is one stage short or long releases the core a cycle early or late, and a check fails. It samples right after a request rises with no clock edge in between; a design that captures requests synchronously shows the line still high at that point. It holds `sw_req` high well past the hold time and also through a power-on reset. A level-sensitive or wrongly preset edge detector would keep the core in reset, or reset it a second time. The bench also confirms that debugger and software requests leave the debug and power-management lines high, which catches any mis-wired domain mask.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;
  // Index of each reset domain in the distributor's domain vector
  typedef enum int unsigned {
    DOM_DBG  = 0,
    DOM_CORE = 1,
    DOM_PMU  = 2
  } rst_dom_e;

  localparam int NUM_DOM = 3;
endpackage

// File: rtl/rst_swreq_edge.sv
// Turns the software reset request into one clock-wide pulse on its rising
// edge. During power-on reset the history bit is preset to 1, so a request
// already high at power-on release is not taken as a new edge.
module rst_swreq_edge (
  input  logic clk,
  input  logic por,
  input  logic req,
  output logic pulse
);
  logic prev;

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      prev  <= 1'b1;
      pulse <= 1'b0;
    end else begin
      prev  <= req;
      pulse <= req & ~prev;
    end
  end
endmodule

// File: rtl/rst_hold_sync.sv
// One reset domain. A request asserts the output at once. Once the request
// is gone, a down-counter holds the reset for HOLD_CYCLES clocks, then a
// shift chain of SYNC_STAGES flops releases it on a clock edge.
module rst_hold_sync #(
  parameter int HOLD_CYCLES = 4,   // must be >= 1
  parameter int SYNC_STAGES = 2    // must be >= 2
) (
  input  logic clk,
  input  logic req,
  output logic rst_n
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic [CNT_W-1:0]       hold_cnt;
  logic [SYNC_STAGES-1:0] chain;

  always_ff @(posedge clk or posedge req) begin
    if (req) begin
      hold_cnt <= CNT_W'(HOLD_CYCLES);
      chain    <= '0;
    end else begin
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      chain <= {chain[SYNC_STAGES-2:0], (hold_cnt == '0)};
    end
  end

  assign rst_n = chain[SYNC_STAGES-1];
endmodule

// File: rtl/cpu_reset_dist.sv
module cpu_reset_dist #(
  parameter int HOLD_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_req,
  input  logic dbg_req,
  input  logic sw_req,
  output logic dbg_rst_n,
  output logic core_rst_n,
  output logic pmu_rst_n
);
  import cpu_rst_pkg::*;

  logic               sw_pulse;
  logic [NUM_DOM-1:0] dom_req;
  logic [NUM_DOM-1:0] dom_rst_n;

  rst_swreq_edge u_swedge (
    .clk   (clk),
    .por   (por_req),
    .req   (sw_req),
    .pulse (sw_pulse)
  );

  // Scope of each source: power-on reaches every domain,
  // debugger and software requests reach only the core.
  always_comb begin
    dom_req           = {NUM_DOM{por_req}};
    dom_req[DOM_CORE] = por_req | dbg_req | sw_pulse;
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    rst_hold_sync #(
      .HOLD_CYCLES (HOLD_CYCLES),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_dom (
      .clk   (clk),
      .req   (dom_req[d]),
      .rst_n (dom_rst_n[d])
    );
  end

  assign dbg_rst_n  = dom_rst_n[DOM_DBG];
  assign core_rst_n = dom_rst_n[DOM_CORE];
  assign pmu_rst_n  = dom_rst_n[DOM_PMU];
endmodule

// File: rtl/cpu_reset_dist_chk.sv
module cpu_reset_dist_chk #(
  parameter int HOLD_CYCLES = 4
) (
  input logic clk,
  input logic por_req,
  input logic dbg_req,
  input logic sw_pulse,
  input logic dbg_rst_n,
  input logic core_rst_n,
  input logic pmu_rst_n
);
  localparam int QW = $clog2(HOLD_CYCLES + 2);

  logic [1:0]    since_por;
  logic [QW-1:0] core_quiet;
  logic          core_src;

  assign core_src = por_req | dbg_req | sw_pulse;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) since_por <= '0;
    else if (since_por != 2'd3) since_por <= since_por + 2'd1;
  end

  always_ff @(posedge clk or posedge core_src) begin
    if (core_src) core_quiet <= '0;
    else if (int'(core_quiet) < HOLD_CYCLES + 1) core_quiet <= core_quiet + 1'b1;
  end

  a_r1_por_all_low: assert property (@(posedge clk)
    por_req |-> (!dbg_rst_n && !core_rst_n && !pmu_rst_n));

  a_r4_core_hold_min: assert property (@(posedge clk) disable iff (por_req)
    $rose(core_rst_n) |-> int'(core_quiet) >= HOLD_CYCLES);

  a_r5_sw_pulse_resets_core: assert property (@(posedge clk) disable iff (por_req)
    sw_pulse |-> !core_rst_n);

  a_r6_sw_pulse_single: assert property (@(posedge clk) disable iff (por_req)
    sw_pulse |=> !sw_pulse);

  a_r8_dbg_line_por_only: assert property (@(posedge clk) disable iff (por_req)
    (since_por >= 2'd2 && $past(dbg_rst_n)) |-> dbg_rst_n);

  a_r8_pmu_line_por_only: assert property (@(posedge clk) disable iff (por_req)
    (since_por >= 2'd2 && $past(pmu_rst_n)) |-> pmu_rst_n);
endmodule

bind cpu_reset_dist cpu_reset_dist_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk        (clk),
  .por_req    (por_req),
  .dbg_req    (dbg_req),
  .sw_pulse   (sw_pulse),
  .dbg_rst_n  (dbg_rst_n),
  .core_rst_n (core_rst_n),
  .pmu_rst_n  (pmu_rst_n)
);

// File: tb/cpu_reset_dist_test.sv
module cpu_reset_dist_test;
  localparam int HOLD = 4;
  localparam int SYNC = 2;
  localparam int REL  = HOLD + SYNC;
  localparam int SRC_POR = 0, SRC_DBG = 1, SRC_SW = 2;
  localparam int D_DBG = 0, D_CORE = 1, D_PMU = 2;

  logic clk = 1'b0;
  logic por_req = 1'b1, dbg_req = 1'b0, sw_req = 1'b0;
  logic dbg_rst_n, core_rst_n, pmu_rst_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  cpu_reset_dist #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .por_req(por_req), .dbg_req(dbg_req), .sw_req(sw_req),
    .dbg_rst_n(dbg_rst_n), .core_rst_n(core_rst_n), .pmu_rst_n(pmu_rst_n)
  );

  // Expected "reset asserted" for domain dom, k negedges after the request rose.
  function automatic bit exp_low(int src, int len, int k, int dom);
    if (src == SRC_SW) return (dom == D_CORE) && k >= 1 && k <= REL + 1;
    if (src == SRC_DBG && dom != D_CORE) return 1'b0;
    return k <= len + REL - 1;
  endfunction

  function automatic string pick_tag(int src, int len, int k, int dom);
    if (src != SRC_POR && dom != D_CORE) return "R8";
    if (src == SRC_POR) return (k <= len) ? "R1" : "R2";
    if (src == SRC_DBG) return (k <= len) ? "R3" : "R4";
    return (len > REL + 1) ? "R6" : "R5";
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic check_all(int src, int len, int k, string force_tag);
    logic [2:0] act;
    act = {pmu_rst_n, core_rst_n, dbg_rst_n};
    for (int d = 0; d < 3; d++) begin
      string t;
      t = (force_tag != "") ? force_tag : pick_tag(src, len, k, d);
      chk(t, act[d], ~exp_low(src, len, k, d));
    end
  endtask

  task automatic set_src(int src, logic v);
    case (src)
      SRC_POR: por_req = v;
      SRC_DBG: dbg_req = v;
      default: sw_req  = v;
    endcase
  endtask

  // Raise a request at a negedge, hold it for len negedges, then follow release.
  task automatic run_scn(int src, int len, string force_tag);
    @(negedge clk);
    set_src(src, 1'b1);
    #1;
    check_all(src, len, 0, force_tag);   // asynchronous assertion
    for (int k = 1; k <= len + REL + 3; k++) begin
      @(negedge clk);
      check_all(src, len, k, force_tag);
      if (k == len) set_src(src, 1'b0);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: t=%0t actual=running expected=finished", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    // Reset state while the power-on request is held (R1)
    repeat (2) @(negedge clk);
    chk("R1", dbg_rst_n, 1'b0);
    chk("R1", core_rst_n, 1'b0);
    chk("R1", pmu_rst_n, 1'b0);
    por_req = 1'b0;
    repeat (REL + 2) @(negedge clk);
    chk("R2", {dbg_rst_n, core_rst_n, pmu_rst_n} == 3'b111, 1'b1);

    // Directed corners
    run_scn(SRC_POR, 3, "");
    run_scn(SRC_DBG, 1, "");
    run_scn(SRC_SW, 1, "");
    run_scn(SRC_SW, 20, "");   // held software request: one reset only (R6)
    repeat (2) @(negedge clk);
    run_scn(SRC_SW, 2, "");    // low then high again: a fresh reset (R6)

    // Software request held through power-on: only the power-on reset (R7)
    @(negedge clk);
    sw_req = 1'b1;
    run_scn(SRC_POR, 3, "R7");
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R7", core_rst_n, 1'b1);
    end
    sw_req = 1'b0;
    repeat (3) @(negedge clk);

    // Constrained random scenarios
    for (int n = 0; n < 40; n++) begin
      int src, len;
      src = $urandom_range(0, 2);
      len = $urandom_range(1, 9);
      run_scn(src, len, "");
      repeat ($urandom_range(1, 3)) @(negedge clk);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule